// File: doc/BRIEF.md
# Burst Address Counter for a Synchronous Burst SRAM

This block produces the address that a synchronous burst SRAM presents to its array on every cycle. When either of two start strobes is seen at a rising clock edge, it captures an external address. From then on it produces the rest of a four-beat burst by itself. It steps only on cycles where the advance input is high, and it changes only the two least-significant address bits. The upper bits stay at the captured value until the next start strobe.

A static order input picks the burst sequence. One setting gives a linear sequence that wraps within the four-beat block. The other gives an interleaved sequence, in which the beat index is XORed into the start offset. Bursting is optional: a strobe on every cycle loads a fresh external address each cycle, with no idle cycles in between. The address output is driven from registers, through a small select mux.

Top module: `burst_addr_gen`

## Requirements
- R1: While rstN is low, and after its release until the first load, addrOut is all zeros.
- R2: If strobeProc, strobeCtrl or both are high at a rising edge, addrOut equals the addrIn sampled at that edge from just after that edge.
- R3: At each rising edge where advance is high and neither strobe is high, the beat index n moves to (n+1) mod 4. After four such edges, addrOut returns to the loaded address.
- R4: When orderLinear is 1, addrOut[1:0] equals (start[1:0] + n) mod 4, where start is the loaded address.
- R5: When orderLinear is 0, addrOut[1:0] equals start[1:0] XOR n. This value of 0 is the default order.
- R6: During a burst, addrOut[ADDR_W-1:2] stays equal to bits ADDR_W-1:2 of the loaded address.
- R7: At a rising edge with no strobe and no advance, the loaded address and the beat index are held, so addrOut does not change.
- R8: If a strobe and advance are both high at the same edge, the new address is loaded and the beat index restarts at 0.
- R9: Strobes on consecutive edges load a new address on every edge, and each address appears in the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | ADDR_W | External address, captured on a strobe |
| strobeProc | input | 1 | First start strobe |
| strobeCtrl | input | 1 | Second start strobe |
| advance | input | 1 | Step the burst by one beat |
| orderLinear | input | 1 | 1 = linear wrap order, 0 = interleaved order (default) |
| addrOut | output | ADDR_W | Current burst address |

## Verification
Two functions can fall on the same edge: loading a new address and stepping the burst. The bench creates that clash in directed cycles, raising advance together with one strobe, the other strobe, or both, in the middle of a burst whose beat index is not zero. It also lets the clash happen often during the random phase. The result is judged by checking that addrOut after the edge equals the new addrIn exactly, with beat 0 in the selected order, and that the next plain advance continues from that new start.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEATS = 4;
  localparam int CNT_W = $clog2(BEATS);

  typedef struct packed {
    logic load;
    logic step;
  } ctlStrobes_t;
endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
  import burst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        strobeProc,
  input  logic        strobeCtrl,
  input  logic        advance,
  output ctlStrobes_t ctl
);
  logic anyStrobe;

  always_comb begin
    anyStrobe = strobeProc | strobeCtrl;
    ctl.load  = anyStrobe;
    ctl.step  = advance & ~anyStrobe;
  end

  // R8: a load and a step never reach the datapath together
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.load, ctl.step}));

  // R8: advance with a strobe turns into a load only
  a_r8_strobe_wins: assert property (@(posedge clk) disable iff (!rstN)
    (advance && (strobeProc || strobeCtrl)) |-> (ctl.load && !ctl.step));
endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              orderLinear,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] baseReg;
  logic [CNT_W-1:0]  cntReg;
  logic [CNT_W-1:0]  lowLinear;
  logic [CNT_W-1:0]  lowInterleave;
  logic [CNT_W-1:0]  lowSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= '0;
      cntReg  <= '0;
    end else if (ctl.load) begin
      baseReg <= addrIn;
      cntReg  <= '0;
    end else if (ctl.step) begin
      cntReg  <= cntReg + 1'b1;
    end
  end

  always_comb begin
    lowLinear     = baseReg[CNT_W-1:0] + cntReg;
    lowInterleave = baseReg[CNT_W-1:0] ^ cntReg;
    lowSel        = orderLinear ? lowLinear : lowInterleave;
    addrOut       = {baseReg[ADDR_W-1:CNT_W], lowSel};
  end

  // R2: a load puts the sampled address on the output at the next edge
  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (addrOut == $past(addrIn)));

  // R3: a step moves the beat index by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> (cntReg == CNT_W'($past(cntReg) + 1'b1)));

  // R6: the upper bits do not move while stepping
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> $stable(addrOut[ADDR_W-1:CNT_W]));

  // R7: an idle cycle keeps all state
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> ($stable(baseReg) && $stable(cntReg)));

  initial begin
    a_r6_width_ok: assert (HI_W > 0);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              strobeProc,
  input  logic              strobeCtrl,
  input  logic              advance,
  input  logic              orderLinear,
  output logic [ADDR_W-1:0] addrOut
);
  ctlStrobes_t ctl;

  burst_ctl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .strobeProc (strobeProc),
    .strobeCtrl (strobeCtrl),
    .advance    (advance),
    .ctl        (ctl)
  );

  burst_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .addrIn      (addrIn),
    .orderLinear (orderLinear),
    .addrOut     (addrOut)
  );

  // R1: the output is cleared while reset is held
  a_r1_reset_zero: assert property (@(posedge clk)
    !rstN |-> (addrOut == '0));
endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int ADDR_W = 19;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              strobeProc = 1'b0;
  logic              strobeCtrl = 1'b0;
  logic              advance = 1'b0;
  logic              orderLinear = 1'b0;
  logic [ADDR_W-1:0] addrOut;

  int checks = 0;
  int fails = 0;
  logic [ADDR_W-1:0] refBase = '0;
  logic [1:0]        refN = '0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .strobeProc(strobeProc),
    .strobeCtrl(strobeCtrl), .advance(advance), .orderLinear(orderLinear),
    .addrOut(addrOut)
  );

  function automatic logic [ADDR_W-1:0] expAddr(logic [ADDR_W-1:0] b, logic [1:0] n, logic lin);
    logic [1:0] lo;
    lo = lin ? 2'(b[1:0] + n) : (b[1:0] ^ n);
    return {b[ADDR_W-1:2], lo};
  endfunction

  task automatic check(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle, update the model at the edge, then check after it.
  task automatic cyc(logic sp, logic sc, logic adv, logic lin, logic [ADDR_W-1:0] a);
    string tag;
    logic [ADDR_W-1:0] prevOut;
    @(negedge clk);
    strobeProc = sp; strobeCtrl = sc; advance = adv; orderLinear = lin; addrIn = a;
    prevOut = addrOut;
    @(posedge clk);
    if (sp || sc) begin
      refBase = a; refN = 2'd0;
      tag = adv ? "R8" : "R2";
    end else if (adv) begin
      refN = refN + 2'd1;
      tag = lin ? "R4" : "R5";
    end else begin
      tag = "R7";
    end
    #1;
    check(tag, addrOut, expAddr(refBase, refN, lin));
    if (!(sp || sc)) check("R6", {addrOut[ADDR_W-1:2], 2'b00}, {refBase[ADDR_W-1:2], 2'b00});
    if (!(sp || sc) && !adv && lin == orderLinear) check("R7", addrOut, prevOut);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] start;
    void'($urandom(7));
    #7;
    check("R1", addrOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", addrOut, '0);

    // R3/R5: interleaved burst from offset 2 wraps back after four steps
    start = 19'h1234A;
    cyc(1, 0, 0, 0, start);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, '0);
    check("R3", addrOut, start);
    // R3/R4: linear burst from offset 3 via the second strobe
    start = 19'h7FFF7;
    cyc(0, 1, 0, 1, start);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, '0);
    check("R3", addrOut, start);
    // R7: idle cycles mid-burst
    cyc(1, 1, 0, 1, 19'h00101);
    cyc(0, 0, 1, 1, '0);
    cyc(0, 0, 0, 1, '0);
    cyc(0, 0, 0, 1, '0);
    cyc(0, 0, 1, 1, '0);
    // R8: strobe with advance mid-burst, each strobe and both
    cyc(1, 0, 1, 0, 19'h2AAA9);
    cyc(0, 0, 1, 0, '0);
    cyc(0, 1, 1, 0, 19'h05556);
    cyc(0, 0, 1, 0, '0);
    cyc(1, 1, 1, 1, 19'h3C3C3);
    cyc(0, 0, 1, 1, '0);
    // R9: a new address on every edge
    for (int i = 0; i < 8; i++) cyc(i[0], ~i[0], 0, 0, ADDR_W'(19'h11111 * i + 3));

    // Random phase; order changes only together with a load
    for (int i = 0; i < 3000; i++) begin
      logic sp, sc, adv, ld;
      sp  = ($urandom % 5) == 0;
      sc  = ($urandom % 5) == 0;
      adv = ($urandom % 3) != 0;
      ld  = sp | sc;
      cyc(sp, sc, adv, ld ? 1'($urandom) : orderLinear, ADDR_W'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule